// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block runs on the fast clock that feeds two output dividers, bank A and bank C. Each divider has its own ratio. When the two ratios are not integer multiples of each other, the divided clocks share a rising edge only once in a while. The block drives one active-low strobe, `sync_n`, which goes low one period of the faster divided clock ahead of each shared rising edge. Logic downstream can then line up with the next coincidence before it happens. The faster of the two divided clocks sets both the length of the pulse and its placement.

Both ratios are sampled on every rising edge of `clk`. The phase reference is cycle t = 0, the cycle just after an edge that either saw reset or saw a ratio pair different from the one held. In that cycle both divided clocks are taken to rise together. For ratios a and c, the fast period is P = min(a, c). The pattern span S is lcm(a, c) when the ratios differ and 2·P when they are equal. Shared rising edges then fall on every cycle t = k·S with k ≥ 1. The dividers that make the bank clocks must restart in the same cycle as this block.

Top module: `cesync_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `sync_n` is high in the following cycle. After reset is released, `sync_n` is high at t = 0.
- R2: Any ratio input below 2 (0 or 1) is treated as 2. For example, the pair (1, 3) behaves like (2, 3), and (0, 0) behaves like (2, 2).
- R3: Each low pulse on `sync_n` lasts exactly P = min(a, c) consecutive `clk` cycles.
- R4: Each low pulse ends in cycle k·S − 1. The shared rising edge falls in cycle k·S, and `sync_n` is high again in that cycle.
- R5: `sync_n` is low exactly in the cycles where (t mod S) ≥ S − P and is high in every other cycle. The first pulse after t = 0 therefore starts at t = S − P, which warns of the first shared edge after the restart.
- R6: When the two ratios are equal, the span is 2·P. `sync_n` then alternates P cycles high and P cycles low, starting high at t = 0.
- R7: Ratio pairs where one ratio divides the other (such as 2:1, 3:1, 4:1 and 6:1) follow the same rule, with S equal to the larger ratio.
- R8: When the sampled pair (after the floor of R2) differs from the held pair, the block restarts. The next cycle becomes t = 0 with `sync_n` high, and any pulse in progress ends at once.
- R9: The output depends only on the unordered pair of ratios, so swapping the A and C ratios produces the same `sync_n` waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast (undivided) clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_a | input | RATIO_W | Division ratio of bank A |
| ratio_c | input | RATIO_W | Division ratio of bank C |
| sync_n | output | 1 | Registered active-low warning pulse ahead of a shared rising edge |

## Verification
A restart can land in the same cycle as a pulse that is already low. The restart may come from a new ratio pair or from reset. The bench provokes this by changing the ratios, and separately by asserting reset, while `sync_n` is inside its low window. It then judges that `sync_n` is high in the very next cycle and that the new pattern is counted from t = 0. A second overlap occurs with equal ratios: each shared edge reaches the pulse logic, but only every second one may open a pulse. The full sweep of equal pairs checks this alternation cycle by cycle against the arithmetic model.

// File: rtl/cesync_pkg.sv
package cesync_pkg;
  // default width of a division ratio field
  localparam int RATIO_W_DEF = 5;
  // smallest ratio the dividers accept; lower codes are raised to it
  localparam int MIN_RATIO   = 2;
endpackage

// File: rtl/cesync_cfg_track.sv
module cesync_cfg_track #(
  parameter int RW   = 5,
  parameter int MINR = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] ratio_a,
  input  logic [RW-1:0] ratio_c,
  output logic [RW-1:0] cfg_a,
  output logic [RW-1:0] cfg_c,
  output logic [RW-1:0] fast_per,
  output logic [RW-1:0] init_a,
  output logic [RW-1:0] init_c,
  output logic          equal_mode,
  output logic          restart
);
  localparam logic [RW-1:0] FLOOR = RW'(MINR);

  logic [RW-1:0] cl_a, cl_c, new_min;
  logic [RW:0]   ahead;

  // raise out-of-range ratios to the floor
  assign cl_a    = (ratio_a < FLOOR) ? FLOOR : ratio_a;
  assign cl_c    = (ratio_c < FLOOR) ? FLOOR : ratio_c;
  assign new_min = (cl_a < cl_c) ? cl_a : cl_c;

  // look-ahead phase at t=0 is (P+1) mod ratio; P+1 never reaches twice a ratio
  assign ahead  = {1'b0, new_min} + {{RW{1'b0}}, 1'b1};
  assign init_a = (ahead >= {1'b0, cl_a}) ? RW'(ahead - {1'b0, cl_a}) : ahead[RW-1:0];
  assign init_c = (ahead >= {1'b0, cl_c}) ? RW'(ahead - {1'b0, cl_c}) : ahead[RW-1:0];

  assign restart = rst || (cl_a != cfg_a) || (cl_c != cfg_c);

  always_ff @(posedge clk) begin
    if (restart) begin
      cfg_a <= cl_a;
      cfg_c <= cl_c;
    end
  end

  assign fast_per   = (cfg_a < cfg_c) ? cfg_a : cfg_c;
  assign equal_mode = (cfg_a == cfg_c);

  // R2
  cfg_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_a >= FLOOR) && (cfg_c >= FLOOR));
endmodule

// File: rtl/cesync_phase_ctr.sv
module cesync_phase_ctr #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [RW-1:0] init,
  input  logic [RW-1:0] modulus,
  output logic [RW-1:0] phase,
  output logic          at_zero
);
  localparam logic [RW-1:0] ONE = RW'(1);

  always_ff @(posedge clk) begin
    if (restart)
      phase <= init;
    else if (phase == modulus - ONE)
      phase <= '0;
    else
      phase <= phase + ONE;
  end

  assign at_zero = (phase == '0);

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    !restart |-> (phase < modulus));
endmodule

// File: rtl/cesync_pulse_shaper.sv
module cesync_pulse_shaper #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          hit,
  input  logic          equal_mode,
  input  logic [RW-1:0] fast_per,
  output logic          sync_n
);
  localparam logic [RW-1:0] ONE = RW'(1);

  logic [RW-1:0] wleft;
  logic          parity;
  logic          fire;

  // with equal ratios every shared edge is a hit; only every second one opens a pulse
  assign fire = hit && (!equal_mode || !parity);

  always_ff @(posedge clk) begin
    if (restart) begin
      sync_n <= 1'b1;
      wleft  <= '0;
      parity <= 1'b0;
    end else begin
      if (hit && equal_mode)
        parity <= !parity;
      if (fire) begin
        sync_n <= 1'b0;
        wleft  <= fast_per - ONE;
      end else if (wleft != '0) begin
        sync_n <= 1'b0;
        wleft  <= wleft - ONE;
      end else begin
        sync_n <= 1'b1;
      end
    end
  end

  // checker: length of the current low run
  logic [RW:0] lowcnt;
  always_ff @(posedge clk) begin
    if (restart)
      lowcnt <= '0;
    else if (!sync_n)
      lowcnt <= lowcnt + 1'b1;
    else
      lowcnt <= '0;
  end

  // R8
  restart_release_chk: assert property (@(posedge clk)
    restart |=> sync_n);

  // R5
  fire_idle_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> (sync_n && (wleft == '0)));

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sync_n) && !$past(restart)) |-> (lowcnt == {1'b0, fast_per}));
endmodule

// File: rtl/cesync_gen.sv
module cesync_gen #(
  parameter int RATIO_W = cesync_pkg::RATIO_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_a,
  input  logic [RATIO_W-1:0] ratio_c,
  output logic               sync_n
);
  localparam int NBANK = 2;

  logic [RATIO_W-1:0] cfg_a, cfg_c, fast_per, init_a, init_c;
  logic               equal_mode, restart;
  logic [RATIO_W-1:0] mod_v  [NBANK];
  logic [RATIO_W-1:0] init_v [NBANK];
  logic [RATIO_W-1:0] ph_v   [NBANK];
  logic [NBANK-1:0]   zero_v;
  logic               hit;

  cesync_cfg_track #(.RW(RATIO_W), .MINR(cesync_pkg::MIN_RATIO)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .ratio_a    (ratio_a),
    .ratio_c    (ratio_c),
    .cfg_a      (cfg_a),
    .cfg_c      (cfg_c),
    .fast_per   (fast_per),
    .init_a     (init_a),
    .init_c     (init_c),
    .equal_mode (equal_mode),
    .restart    (restart)
  );

  assign mod_v[0]  = cfg_a;
  assign mod_v[1]  = cfg_c;
  assign init_v[0] = init_a;
  assign init_v[1] = init_c;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    cesync_phase_ctr #(.RW(RATIO_W)) u_ph (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .init    (init_v[b]),
      .modulus (mod_v[b]),
      .phase   (ph_v[b]),
      .at_zero (zero_v[b])
    );
  end

  assign hit = &zero_v;

  cesync_pulse_shaper #(.RW(RATIO_W)) u_shape (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .hit        (hit),
    .equal_mode (equal_mode),
    .fast_per   (fast_per),
    .sync_n     (sync_n)
  );
endmodule

// File: tb/tb_cesync_gen.sv
`timescale 1ns/1ps
module tb_cesync_gen;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [RW-1:0] ra  = RW'(3);
  logic [RW-1:0] rc  = RW'(4);
  logic          sync_n;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  cesync_gen #(.RATIO_W(RW)) dut (
    .clk(clk), .rst(rst), .ratio_a(ra), .ratio_c(rc), .sync_n(sync_n)
  );

  function automatic int clampr(int v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic int gcd(int x, int y);
    int p = x;
    int q = y;
    while (q != 0) begin
      int r = p % q;
      p = q;
      q = r;
    end
    return p;
  endfunction

  function automatic int span(int a, int c);
    int ac = clampr(a);
    int cc = clampr(c);
    if (ac == cc) return 2 * ac;
    return ac * cc / gcd(ac, cc);
  endfunction

  function automatic int fper(int a, int c);
    int ac = clampr(a);
    int cc = clampr(c);
    return (ac < cc) ? ac : cc;
  endfunction

  function automatic bit exp_n(int a, int c, int t);
    int s = span(a, c);
    int p = fper(a, c);
    return !((t % s) >= s - p);
  endfunction

  task automatic chk(bit exp, string tag, int a, int c, int t);
    n_vec++;
    if (sync_n !== exp) begin
      n_bad++;
      $display("FAIL %s ratios=(%0d,%0d) t=%0d sync_n got %b expected %b",
               tag, a, c, t, sync_n, exp);
    end
  endtask

  function automatic string auto_tag(int a, int c, int t);
    int s = span(a, c);
    if (a < 2 || c < 2) return "R2";
    if (a == c) return "R6";
    if (a % c == 0 || c % a == 0) return "R7";
    if (t == 0) return "R8";
    if (!exp_n(a, c, t)) return "R3";
    if (t > 0 && (t % s) == 0) return "R4";
    return "R5";
  endfunction

  // continue an ongoing pattern from cycle t0
  task automatic run_from(int a, int c, int t0, int ncyc, string tag);
    for (int t = t0; t < t0 + ncyc; t++) begin
      @(posedge clk);
      @(negedge clk);
      chk(exp_n(a, c, t), (tag == "") ? auto_tag(a, c, t) : tag, a, c, t);
    end
  endtask

  // called at a falling edge: apply a new pair, check from t=0
  task automatic run_pair(int a, int c, int ncyc, string tag);
    ra = RW'(a);
    rc = RW'(c);
    run_from(a, c, 0, ncyc, tag);
  endtask

  initial begin
    // R1: reset state
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      chk(1'b1, "R1", 3, 4, 0);
    end
    rst = 1'b0;
    chk(1'b1, "R1", 3, 4, 0);
    run_from(3, 4, 1, 36, "");

    // exhaustive sweep of a small ratio range
    for (int a = 2; a <= 8; a++) begin
      for (int c = 2; c <= 8; c++) begin
        run_pair(a, c, 2 * span(a, c) + fper(a, c) + 2, "");
      end
    end

    // R9: swapped banks give the same waveform
    run_pair(5, 3, 40, "R9");
    run_pair(3, 5, 40, "R9");

    // R2: ratios below the floor
    run_pair(1, 3, 20, "R2");
    run_pair(0, 0, 12, "R2");

    // R8: change ratios while the pulse is low (t=9 of (3,4) is low)
    run_pair(3, 4, 10, "R8");
    run_pair(4, 6, 30, "R8");

    // R1: reset while a pulse of (5,7) is low (t=30..34)
    run_pair(5, 7, 33, "");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(1'b1, "R1", 5, 7, 0);
    rst = 1'b0;
    chk(1'b1, "R1", 5, 7, 0);
    run_from(5, 7, 1, 75, "");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: got no completion expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule